// File: doc/BRIEF.md
# DMA channel cancel and retire controller

This block is the control core of a single-channel DMA engine that moves data in read/write beat pairs. When started it takes a byte count and an iteration count. It asks for a grant, then runs pairs: one read beat, then the write beat that goes with it. Each completed write takes `BEAT_BYTES` off the remaining count. When the count reaches zero, one minor loop is complete. The channel then moves to the next iteration, either by asking for a fresh grant or, in continuous-link mode with a self link, by going straight back to reading. After the last iteration it signals done.

Software controls the channel through a small register port. The control word holds two self-clearing cancel requests, a normal one and an error one, plus halt, continuous-link and loop-mapping controls. A cancel never splits a pair. The channel stops at the next pair boundary and retires as if its minor loop had ended, and the cancel bit then drops back to zero. An error cancel also sets a sticky flag in an error status word. That flag drives a level interrupt when it is enabled, and software clears it with a write-one-to-clear.

Top module: `dma_cancel_ctl`

## Requirements
- R1: The control word is at address 0 with bit 17 normal cancel, bit 16 error cancel, bit 7 loop mapping, bit 6 continuous link and bit 5 halt. All bits reset to 0. Reads return the addressed word on `reg_rdata` one clock after the address is presented.
- R2: Bits 31–18 and 15–8 of the control word read as zero whatever is written to them.
- R3: A cancel never leaves a read without its write. Once a read has been accepted, the matching write completes before the channel retires, and no read is requested while a cancel is pending. At every retirement the count of accepted reads equals the count of accepted writes.
- R4: A cancel takes effect in the ARB or RD state, or on the write acknowledge that ends the pair in flight. On that edge `done` pulses for one cycle and `active` falls. `iters_left` drops by one, as at a minor-loop end. `bytes_left` keeps the value left by the last completed write and does not change afterwards.
- R5: A cancel bit clears itself on the edge where the channel retires, so a later read of it returns 0.
- R6: A cancel bit written while no transfer is active clears on the next clock edge. It produces no `done` pulse and no error flag.
- R7: Error status is at address 1, with the cancel-error flag in bit 0. An error cancel sets the flag when it retires the channel. A normal cancel leaves it clear.
- R8: When both cancel bits are written together, the error cancel wins. The channel retires once, with a single `done` pulse and one error record.
- R9: Interrupt enable is bit 0 at address 2. `err_irq` is high while the flag and the enable are both set. It stays high until the flag is cleared by writing 1 to bit 0 at address 1.
- R10: Each accepted write lowers `bytes_left` by `BEAT_BYTES`, saturating at 0. At 0 the minor loop ends. After the last iteration `done` pulses and the channel goes idle. An iteration count of 0 runs as 1.
- R11: With continuous link set and `self_link` high, the next minor loop starts reading without raising `arb_req`. Otherwise the channel raises `arb_req` and waits for `arb_grant` before each minor loop.
- R12: While halt is set no new read is requested. A write already waiting for its acknowledge still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address, for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the address of the previous cycle |
| start | input | 1 | Load configuration and activate the channel (ignored while active) |
| cfg_nbytes | input | CNT_W | Bytes per minor loop |
| cfg_iters | input | ITER_W | Number of minor loops |
| self_link | input | 1 | Channel links to itself at minor-loop end |
| arb_req | output | 1 | Request for a grant |
| arb_grant | input | 1 | Grant answer |
| rd_req | output | 1 | Read beat request |
| rd_ack | input | 1 | Read beat accepted |
| wr_req | output | 1 | Write beat request |
| wr_ack | input | 1 | Write beat accepted |
| bytes_left | output | CNT_W | Remaining bytes in the current minor loop |
| iters_left | output | ITER_W | Remaining minor loops |
| active | output | 1 | Channel is running |
| done | output | 1 | One-cycle retire pulse |
| err_irq | output | 1 | Error interrupt level |

## Verification
The bench builds the block with `CNT_W` 12, `ITER_W` 4 and `BEAT_BYTES` 4. Minor loops of two to sixteen pairs and runs of up to three iterations therefore finish in a few dozen cycles. This makes it cheap to place a cancel while a write is held off, while the channel waits for a grant, and in the idle state. A 10-byte loop that is not a multiple of the beat size exercises the saturating last write. Acknowledge and grant patterns of different periods make pairs, grants and stalls overlap in many alignments.

// File: rtl/dmacc_pkg.sv
package dmacc_pkg;

  localparam int REG_W      = 32;
  localparam int CTL_CX     = 17;
  localparam int CTL_ECX    = 16;
  localparam int CTL_MLM    = 7;
  localparam int CTL_CLM    = 6;
  localparam int CTL_HALT   = 5;

  localparam int ADDR_CTL   = 0;
  localparam int ADDR_ERR   = 1;
  localparam int ADDR_IEN   = 2;

  localparam logic [REG_W-1:0] CTL_LIVE_MASK =
    (32'h1 << CTL_CX) | (32'h1 << CTL_ECX) | (32'h1 << CTL_MLM) |
    (32'h1 << CTL_CLM) | (32'h1 << CTL_HALT);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } seq_st_e;

endpackage

// File: rtl/dmacc_regs.sv
module dmacc_regs import dmacc_pkg::*; #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              retire,
  input  logic              active,
  input  logic              err_flag,
  input  logic              irq_en,
  output logic              cx,
  output logic              ecx,
  output logic              mlm,
  output logic              clm,
  output logic              halt,
  output logic [REG_W-1:0]  rdata
);

  logic wr_ctl;
  logic clr_cancel;
  logic [REG_W-1:0] rd_mux;
  logic unused_wbits;

  assign wr_ctl     = we && (addr == ADDR_W'(ADDR_CTL));
  // A cancel is consumed by a retirement, or dropped when nothing runs
  assign clr_cancel = retire || (!active && (cx || ecx));
  assign unused_wbits = ^(wdata & ~CTL_LIVE_MASK);

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(ADDR_CTL))
      rd_mux = {14'b0, cx, ecx, 8'b0, mlm, clm, halt, 5'b0};
    else if (addr == ADDR_W'(ADDR_ERR))
      rd_mux = {31'b0, err_flag};
    else if (addr == ADDR_W'(ADDR_IEN))
      rd_mux = {31'b0, irq_en};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cx    <= 1'b0;
      ecx   <= 1'b0;
      mlm   <= 1'b0;
      clm   <= 1'b0;
      halt  <= 1'b0;
      rdata <= '0;
    end else begin
      if (wr_ctl) begin
        mlm  <= wdata[CTL_MLM];
        clm  <= wdata[CTL_CLM];
        halt <= wdata[CTL_HALT];
      end
      cx    <= (cx  && !clr_cancel) || (wr_ctl && wdata[CTL_CX]);
      ecx   <= (ecx && !clr_cancel) || (wr_ctl && wdata[CTL_ECX]);
      rdata <= rd_mux;
    end
  end

  // R2: reserved control bits never show up on a control read
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_W'(ADDR_CTL)) |-> ((rdata & ~CTL_LIVE_MASK) == '0))
    else $error("reserved control bits read non-zero");

  // R6: a cancel with no transfer running is dropped on the next edge
  p_idle_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (!active && (cx || ecx) && !wr_ctl) |=> !(cx || ecx))
    else $error("idle cancel not dropped");

endmodule

// File: rtl/dmacc_err.sv
module dmacc_err import dmacc_pkg::*; #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              retire,
  input  logic              ecx,
  output logic              err_flag,
  output logic              irq_en,
  output logic              err_irq
);

  logic w1c;
  logic wr_en;
  logic flag_nx;
  logic en_nx;
  logic unused_wbits;

  assign w1c     = we && (addr == ADDR_W'(ADDR_ERR)) && wdata[0];
  assign wr_en   = we && (addr == ADDR_W'(ADDR_IEN));
  assign flag_nx = (err_flag && !w1c) || (retire && ecx);
  assign en_nx   = wr_en ? wdata[0] : irq_en;
  assign unused_wbits = ^wdata[REG_W-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      irq_en   <= 1'b0;
      err_irq  <= 1'b0;
    end else begin
      err_flag <= flag_nx;
      irq_en   <= en_nx;
      err_irq  <= flag_nx && en_nx;
    end
  end

  // R7: an error cancel that retires the channel leaves the flag set
  p_err_logged_r7: assert property (@(posedge clk) disable iff (rst)
    (retire && ecx) |=> err_flag)
    else $error("error cancel not logged");

  // R7: a plain cancel never raises the flag
  p_plain_no_err_r7: assert property (@(posedge clk) disable iff (rst)
    (retire && !ecx && !err_flag) |=> !err_flag)
    else $error("plain cancel logged an error");

  // R9: the interrupt level holds until cleared or disabled
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (err_irq && !w1c && !(wr_en && !wdata[0])) |=> err_irq)
    else $error("interrupt dropped without clear");

endmodule

// File: rtl/dmacc_seq.sv
module dmacc_seq import dmacc_pkg::*; #(
  parameter int CNT_W      = 16,
  parameter int ITER_W     = 8,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_nbytes,
  input  logic [ITER_W-1:0] cfg_iters,
  input  logic              self_link,
  input  logic              clm,
  input  logic              halt,
  input  logic              cx,
  input  logic              ecx,
  input  logic              arb_grant,
  input  logic              rd_ack,
  input  logic              wr_ack,
  output logic              arb_req,
  output logic              rd_req,
  output logic              wr_req,
  output logic              retire,
  output logic              active,
  output logic              done,
  output logic [CNT_W-1:0]  bytes_left,
  output logic [ITER_W-1:0] iters_left
);

  localparam logic [CNT_W-1:0]  BEAT   = CNT_W'(BEAT_BYTES);
  localparam logic [ITER_W-1:0] ONE_IT = ITER_W'(1);

  seq_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  reload;
  logic [ITER_W-1:0] iters;
  logic              pend;
  logic              rd_fire;
  logic              wr_fire;
  logic [CNT_W-1:0]  cnt_after;
  logic [ITER_W-1:0] iters_dec;

  assign pend      = cx || ecx;
  assign active    = (st != ST_IDLE);
  assign arb_req   = (st == ST_ARB) && !pend;
  assign rd_req    = (st == ST_RD) && !halt && !pend;
  assign wr_req    = (st == ST_WR);
  assign rd_fire   = rd_req && rd_ack;
  assign wr_fire   = wr_req && wr_ack;
  // Safe boundaries: nothing issued yet, or the pair's write just landed
  assign retire    = pend && ((st == ST_ARB) || (st == ST_RD) || wr_fire);
  assign cnt_after = (cnt <= BEAT) ? '0 : (cnt - BEAT);
  assign iters_dec = (iters == '0) ? '0 : (iters - ONE_IT);

  assign bytes_left = cnt;
  assign iters_left = iters;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      reload <= '0;
      iters  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st     <= ST_ARB;
            cnt    <= cfg_nbytes;
            reload <= cfg_nbytes;
            iters  <= cfg_iters;
          end
        end
        ST_ARB: begin
          if (retire) begin
            st    <= ST_IDLE;
            done  <= 1'b1;
            iters <= iters_dec;
          end else if (arb_grant) begin
            st <= ST_RD;
          end
        end
        ST_RD: begin
          if (retire) begin
            st    <= ST_IDLE;
            done  <= 1'b1;
            iters <= iters_dec;
          end else if (rd_fire) begin
            st <= ST_WR;
          end
        end
        ST_WR: begin
          if (wr_fire) begin
            cnt <= cnt_after;
            if (retire) begin
              st    <= ST_IDLE;
              done  <= 1'b1;
              iters <= iters_dec;
            end else if (cnt_after == '0) begin
              iters <= iters_dec;
              if (iters_dec == '0) begin
                st   <= ST_IDLE;
                done <= 1'b1;
              end else begin
                cnt <= reload;
                st  <= (self_link && clm) ? ST_RD : ST_ARB;
              end
            end else begin
              st <= ST_RD;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: a write waiting for its acknowledge is never abandoned
  p_pair_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> wr_req)
    else $error("write of a pair abandoned");

  // R4: once retired the byte count stays put until a new start
  p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> $stable(bytes_left))
    else $error("byte count moved while idle");

  // R10: a mid-loop write takes one beat off the count
  p_beat_dec_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !pend && (cnt > BEAT)) |=> (bytes_left == $past(cnt) - BEAT))
    else $error("byte count not reduced by one beat");

  // R11: self-linked continuous mode goes straight back to reading
  p_clm_restart_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !pend && (cnt <= BEAT) && (iters > ONE_IT) && self_link && clm)
      |=> (st == ST_RD))
    else $error("continuous link did not restart directly");

  // R12: with halt set no new pair reaches its write phase
  p_halt_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (halt && !wr_req) |=> !wr_req)
    else $error("pair started under halt");

endmodule

// File: rtl/dma_cancel_ctl.sv
module dma_cancel_ctl import dmacc_pkg::*; #(
  parameter int ADDR_W     = 2,
  parameter int CNT_W      = 16,
  parameter int ITER_W     = 8,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_nbytes,
  input  logic [ITER_W-1:0] cfg_iters,
  input  logic              self_link,
  output logic              arb_req,
  input  logic              arb_grant,
  output logic              rd_req,
  input  logic              rd_ack,
  output logic              wr_req,
  input  logic              wr_ack,
  output logic [CNT_W-1:0]  bytes_left,
  output logic [ITER_W-1:0] iters_left,
  output logic              active,
  output logic              done,
  output logic              err_irq
);

  logic cx, ecx, mlm, clm, halt;
  logic retire;
  logic err_flag, irq_en;
  logic cancel_wr;

  assign cancel_wr = reg_we && (reg_addr == ADDR_W'(ADDR_CTL)) &&
                     (reg_wdata[CTL_CX] || reg_wdata[CTL_ECX]);

  dmacc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .retire(retire), .active(active), .err_flag(err_flag), .irq_en(irq_en),
    .cx(cx), .ecx(ecx), .mlm(mlm), .clm(clm), .halt(halt), .rdata(reg_rdata)
  );

  dmacc_seq #(.CNT_W(CNT_W), .ITER_W(ITER_W), .BEAT_BYTES(BEAT_BYTES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cfg_nbytes(cfg_nbytes),
    .cfg_iters(cfg_iters), .self_link(self_link), .clm(clm), .halt(halt),
    .cx(cx), .ecx(ecx), .arb_grant(arb_grant), .rd_ack(rd_ack),
    .wr_ack(wr_ack), .arb_req(arb_req), .rd_req(rd_req), .wr_req(wr_req),
    .retire(retire), .active(active), .done(done), .bytes_left(bytes_left),
    .iters_left(iters_left)
  );

  dmacc_err #(.ADDR_W(ADDR_W)) u_err (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .retire(retire), .ecx(ecx), .err_flag(err_flag), .irq_en(irq_en),
    .err_irq(err_irq)
  );

  // R4: retirement yields a done pulse with the channel idle
  p_retire_done_r4: assert property (@(posedge clk) disable iff (rst)
    retire |=> (done && !active))
    else $error("retire without done");

  // R5: both cancel bits are gone after the retire edge
  p_self_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (retire && !cancel_wr) |=> !(cx || ecx))
    else $error("cancel bit did not self-clear");

  // R8: a joint request is handled as an error cancel
  p_joint_err_r8: assert property (@(posedge clk) disable iff (rst)
    (retire && cx && ecx) |=> err_flag)
    else $error("joint cancel not treated as error");

endmodule

// File: tb/dma_cancel_ctl_bench.sv
module dma_cancel_ctl_bench;

  localparam int ADDR_W = 2;
  localparam int CNT_W  = 12;
  localparam int ITER_W = 4;
  localparam int BEAT   = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  cfg_nbytes = '0;
  logic [ITER_W-1:0] cfg_iters = '0;
  logic              self_link = 1'b0;
  logic              arb_req, rd_req, wr_req;
  logic              arb_grant = 1'b0, rd_ack = 1'b0, wr_ack = 1'b0;
  logic [CNT_W-1:0]  bytes_left;
  logic [ITER_W-1:0] iters_left;
  logic              active, done, err_irq;

  always #5 clk = ~clk;

  dma_cancel_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ITER_W(ITER_W),
                   .BEAT_BYTES(BEAT)) u_dma_cancel_ctl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start(start),
    .cfg_nbytes(cfg_nbytes), .cfg_iters(cfg_iters), .self_link(self_link),
    .arb_req(arb_req), .arb_grant(arb_grant), .rd_req(rd_req), .rd_ack(rd_ack),
    .wr_req(wr_req), .wr_ack(wr_ack), .bytes_left(bytes_left),
    .iters_left(iters_left), .active(active), .done(done), .err_irq(err_irq)
  );

  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0, n_gnt = 0, n_done = 0, cyc = 0;
  bit stall_wr = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Responder: fixed-period acknowledge and grant patterns
  always @(negedge clk) begin
    cyc++;
    rd_ack    <= (cyc % 3) != 1;
    wr_ack    <= !stall_wr && ((cyc % 4) != 2);
    arb_grant <= (cyc % 5) == 0;
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (rd_req && rd_ack) n_rd++;
      if (wr_req && wr_ack) n_wr++;
      if (arb_req && arb_grant) n_gnt++;
      if (done) n_done++;
    end
  end

  // ---------------- behavioural reference model ----------------
  int m_st;                     // 0 idle, 1 grant wait, 2 read, 3 write
  logic [CNT_W-1:0]  m_cnt, m_reload, m_after;
  logic [ITER_W-1:0] m_it, m_itd;
  bit m_cx, m_ecx, m_mlm, m_clm, m_halt, m_flag, m_en, m_irq, m_done, m_ok;
  bit pend, rd_go, wr_go, ret, clr, w1c;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = '0; m_reload = '0; m_it = '0;
      m_cx = 0; m_ecx = 0; m_mlm = 0; m_clm = 0; m_halt = 0;
      m_flag = 0; m_en = 0; m_irq = 0; m_done = 0; m_rdata = '0; m_ok = 1;
    end else begin
      pend  = m_cx || m_ecx;
      rd_go = (m_st == 2) && !m_halt && !pend && rd_ack;
      wr_go = (m_st == 3) && wr_ack;
      ret   = pend && (m_st == 1 || m_st == 2 || wr_go);
      if (reg_addr == 2'd0)
        m_rdata = (32'(m_cx) << 17) | (32'(m_ecx) << 16) | (32'(m_mlm) << 7) |
                  (32'(m_clm) << 6) | (32'(m_halt) << 5);
      else if (reg_addr == 2'd1) m_rdata = 32'(m_flag);
      else if (reg_addr == 2'd2) m_rdata = 32'(m_en);
      else m_rdata = '0;
      m_done = 0;
      m_itd = (m_it == '0) ? '0 : m_it - 1'b1;
      if (ret) begin
        if (wr_go) m_cnt = (m_cnt <= CNT_W'(BEAT)) ? '0 : m_cnt - CNT_W'(BEAT);
        m_st = 0; m_done = 1; m_it = m_itd;
      end else if (m_st == 0 && start) begin
        m_st = 1; m_cnt = cfg_nbytes; m_reload = cfg_nbytes; m_it = cfg_iters;
      end else if (m_st == 1 && arb_grant) begin
        m_st = 2;
      end else if (rd_go) begin
        m_st = 3;
      end else if (wr_go) begin
        m_after = (m_cnt <= CNT_W'(BEAT)) ? '0 : m_cnt - CNT_W'(BEAT);
        m_cnt = m_after;
        if (m_after == '0) begin
          m_it = m_itd;
          if (m_itd == '0) begin m_st = 0; m_done = 1; end
          else begin m_cnt = m_reload; m_st = (self_link && m_clm) ? 2 : 1; end
        end else m_st = 2;
      end
      clr  = ret || (!ret && m_st == 0 && pend && !(wr_go));
      clr  = ret || (pend && !ret && !(m_st != 0 || m_done) );
      w1c  = reg_we && reg_addr == 2'd1 && reg_wdata[0];
      m_flag = (m_flag && !w1c) || (ret && m_ecx);
      if (reg_we && reg_addr == 2'd2) m_en = reg_wdata[0];
      m_irq = m_flag && m_en;
      begin
        bit was_idle;
        was_idle = !ret && !(m_st != 0) && !(start && 0);
      end
      if (reg_we && reg_addr == 2'd0) begin
        m_mlm = reg_wdata[7]; m_clm = reg_wdata[6]; m_halt = reg_wdata[5];
      end
      m_cx  = (m_cx  && !clr) || (reg_we && reg_addr == 2'd0 && reg_wdata[17]);
      m_ecx = (m_ecx && !clr) || (reg_we && reg_addr == 2'd0 && reg_wdata[16]);
    end
  end

  always @(negedge clk) begin
    if (m_ok && !rst) begin
      chk("R11 arb_req model", 32'(arb_req), 32'(m_st == 1 && !(m_cx || m_ecx)));
      chk("R12 rd_req model", 32'(rd_req), 32'(m_st == 2 && !m_halt && !(m_cx || m_ecx)));
      chk("R3 wr_req model", 32'(wr_req), 32'(m_st == 3));
      chk("R4 active model", 32'(active), 32'(m_st != 0));
      chk("R4 done model", 32'(done), 32'(m_done));
      chk("R10 bytes_left model", 32'(bytes_left), 32'(m_cnt));
      chk("R10 iters_left model", 32'(iters_left), 32'(m_it));
      chk("R9 err_irq model", 32'(err_irq), 32'(m_irq));
      chk("R1 reg_rdata model", reg_rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wreg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rreg(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic kick(input int nb, input int it);
    @(negedge clk); start = 1'b1; cfg_nbytes = CNT_W'(nb); cfg_iters = ITER_W'(it);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int d0 = n_done;
    int k = 0;
    while (n_done == d0 && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic wait_wr();
    int k = 0;
    while (!wr_req && k < 3000) begin @(negedge clk); k++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int r0, w0, g0, dn0;
    logic [CNT_W-1:0] b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset active", 32'(active), 0);
    chk("R1 reset done", 32'(done), 0);
    rreg(2'd0, d); chk("R1 reset control word", d, 0);
    rreg(2'd1, d); chk("R7 reset error word", d, 0);

    // R1 / R2: live bits read back, reserved bits stay zero
    wreg(2'd0, 32'hFFFC_FFFF);
    rreg(2'd0, d); chk("R1 R2 control readback", d, 32'h0000_00E0);
    wreg(2'd0, 32'hFFFC_FF1F);
    rreg(2'd0, d); chk("R2 reserved only write", d, 0);

    // R10: normal two-iteration run
    r0 = n_rd; w0 = n_wr; g0 = n_gnt;
    kick(16, 2); wait_done();
    chk("R10 bytes at end", 32'(bytes_left), 0);
    chk("R10 iters at end", 32'(iters_left), 0);
    chk("R10 writes done", 32'(n_wr - w0), 8);
    chk("R11 grants without link", 32'(n_gnt - g0), 2);
    // R10: count not a multiple of the beat saturates
    w0 = n_wr; kick(10, 1); wait_done();
    chk("R10 saturating writes", 32'(n_wr - w0), 3);

    // R11: continuous self link needs a single grant
    wreg(2'd0, 32'h40); self_link = 1'b1;
    g0 = n_gnt; r0 = n_rd;
    kick(8, 3); wait_done();
    chk("R11 grants with continuous link", 32'(n_gnt - g0), 1);
    chk("R11 reads with continuous link", 32'(n_rd - r0), 6);
    self_link = 1'b0; wreg(2'd0, 32'h0);

    // R3 R4 R5 R7: normal cancel with a write held off
    stall_wr = 1'b1;
    kick(64, 2); wait_wr();
    wreg(2'd0, 32'h0002_0000);
    rreg(2'd0, d); chk("R3 cancel pending during pair", d, 32'h0002_0000);
    chk("R3 one read outstanding", 32'(n_rd - n_wr), 1);
    dn0 = n_done; stall_wr = 1'b0; wait_done();
    @(negedge clk);
    chk("R3 reads equal writes", 32'(n_rd), 32'(n_wr));
    chk("R4 bytes after in-flight pair", 32'(bytes_left), 60);
    chk("R4 iteration taken", 32'(iters_left), 1);
    b0 = bytes_left; repeat (10) @(negedge clk);
    chk("R4 bytes frozen", 32'(bytes_left), 32'(b0));
    chk("R4 single done", 32'(n_done - dn0), 1);
    rreg(2'd0, d); chk("R5 cancel self-cleared", d, 0);
    rreg(2'd1, d); chk("R7 no error for plain cancel", d, 0);

    // R7 R9: error cancel while waiting for a grant, interrupt enabled
    wreg(2'd2, 32'h1);
    kick(32, 1); @(negedge clk);
    wreg(2'd0, 32'h0001_0000); wait_done(); @(negedge clk);
    rreg(2'd1, d); chk("R7 error flag set", d, 1);
    rreg(2'd0, d); chk("R5 error cancel self-cleared", d, 0);
    repeat (5) @(negedge clk);
    chk("R9 interrupt held", 32'(err_irq), 1);
    wreg(2'd1, 32'h1); @(negedge clk);
    chk("R9 interrupt cleared", 32'(err_irq), 0);

    // R8: both cancels together
    stall_wr = 1'b1; kick(40, 1); wait_wr();
    dn0 = n_done;
    wreg(2'd0, 32'h0003_0000); stall_wr = 1'b0; wait_done();
    repeat (4) @(negedge clk);
    chk("R8 one done", 32'(n_done - dn0), 1);
    rreg(2'd1, d); chk("R8 error recorded", d, 1);
    chk("R3 joint cancel pairs", 32'(n_rd), 32'(n_wr));
    wreg(2'd1, 32'h1);

    // R6: cancel while idle
    dn0 = n_done;
    wreg(2'd0, 32'h0003_0000); @(negedge clk);
    rreg(2'd0, d); chk("R6 idle cancel dropped", d, 0);
    rreg(2'd1, d); chk("R6 no error", d, 0);
    chk("R6 no done", 32'(n_done - dn0), 0);

    // R12: halt before start blocks reads
    wreg(2'd0, 32'h20); r0 = n_rd;
    kick(16, 1); repeat (20) @(negedge clk);
    chk("R12 no read under halt", 32'(n_rd - r0), 0);
    chk("R12 still active", 32'(active), 1);
    wreg(2'd0, 32'h0); wait_done();
    chk("R12 run after release", 32'(n_rd - r0), 4);
    // R12: halt during a pair lets the write land
    stall_wr = 1'b1; kick(16, 1); wait_wr();
    wreg(2'd0, 32'h20); r0 = n_rd; stall_wr = 1'b0;
    repeat (20) @(negedge clk);
    chk("R12 in-flight write lands", 32'(n_wr), 32'(n_rd));
    chk("R12 no new read", 32'(n_rd - r0), 0);
    wreg(2'd0, 32'h0); wait_done();
    chk("R10 halted run completes", 32'(bytes_left), 0);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule